// File: doc/BRIEF.md
# Data Cache Tag State Checker

This block inspects one data-cache tag entry that has been read back through an index-load path. It is given the 32-bit upper tag word, the 40-bit lower tag field and the 13-bit cache index that was used for the read. From these it decides whether the 5-bit coherence state is one of the six legal encodings. For a legal entry it also checks the two parity bits that guard the physical tag.

The upper tag word also carries the LRU ordering, and the block passes it through. It rebuilds the physical line address and splits the index into a bank and a set number. All results are registered together. A one-cycle strobe launches a check, and the results appear on the next cycle with a valid pulse. They then hold until the next strobe, so error-handling firmware or a scrubber can read them at leisure.

Top module: `dcache_tag_checker`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: The coherence state is `tag_hi[29:25]`. The legal encodings map to `state_code` as follows: 0x00 (invalid) maps to 0, 0x0F (coherent shared) to 1, 0x13 (non-coherent exclusive clean) to 2, 0x19 (non-coherent exclusive dirty) to 3, 0x16 (coherent exclusive clean) to 4, and 0x1C (coherent exclusive dirty) to 5. A legal state gives `state_err` = 0.
- R3: Any other state value gives `state_err` = 1 and `state_code` = 7. In that case `addr_err` is 0 whatever the parity bits hold.
- R4: For a legal state, `tag_lo[11]` must equal the XOR of `tag_lo[39:26]`. A mismatch sets `addr_err`.
- R5: For a legal state, `tag_lo[10]` must equal the XOR of `tag_lo[25:13]`. A mismatch sets `addr_err`.
- R6: `phys_addr` equals `{tag_lo[39:13], line_index[12:0]}`.
- R7: `bank` equals `{line_index[12], line_index[5]}`, and `set_num` equals `line_index[11:6]`.
- R8: `lru_order` equals `tag_hi[21:14]`. Bits [1:0] hold the least recently used way and bits [7:6] hold the most recently used way.
- R9: All results are registered. They appear in the cycle after `chk_valid` is high, and `out_valid` is high for exactly that cycle. Without a strobe, every result output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Strobe: check the presented tag entry |
| tag_hi | input | 32 | Upper tag word (state, LRU) |
| tag_lo | input | 40 | Lower tag field (physical tag, parity bits) |
| line_index | input | 13 | Cache index used for the read |
| out_valid | output | 1 | Results updated this cycle |
| state_err | output | 1 | Illegal coherence state |
| addr_err | output | 1 | Physical tag parity mismatch |
| state_code | output | 3 | Decoded state 0..5, or 7 if illegal |
| phys_addr | output | 40 | Reconstructed physical address |
| bank | output | 2 | Bank number |
| set_num | output | 6 | Set number |
| lru_order | output | 8 | LRU ordering, LRU way in bits [1:0] |

## Verification
A wrong decode entry shows up in the cycle after the strobe. It appears as a wrong `state_code`, as a spurious or missing `state_err`, or as parity errors that leak through for an illegal state. A wrong parity span or a wrong bit pick shows up as an `addr_err` that disagrees for tags whose single flipped bit lies at the edge of a range. Faulty hold logic shows up as outputs that change in the cycles between strobes. The bench compares every output against a behavioural model on every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/dcache_tag_checker.sv
module dcache_tag_checker #(
  parameter int HI_W  = 32,
  parameter int LO_W  = 40,
  parameter int IDX_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_valid,
  input  logic [HI_W-1:0]  tag_hi,
  input  logic [LO_W-1:0]  tag_lo,
  input  logic [IDX_W-1:0] line_index,
  output logic             out_valid,
  output logic             state_err,
  output logic             addr_err,
  output logic [2:0]       state_code,
  output logic [LO_W-1:0]  phys_addr,
  output logic [1:0]       bank,
  output logic [5:0]       set_num,
  output logic [7:0]       lru_order
);
  localparam logic [2:0] BAD_CODE = 3'd7;

  logic [4:0] coh;
  logic [2:0] code_n;
  logic       legal, par_hi_bad, par_lo_bad;

  assign coh = tag_hi[29:25];

  always_comb begin
    case (coh)
      5'h00:   code_n = 3'd0;
      5'h0F:   code_n = 3'd1;
      5'h13:   code_n = 3'd2;
      5'h19:   code_n = 3'd3;
      5'h16:   code_n = 3'd4;
      5'h1C:   code_n = 3'd5;
      default: code_n = BAD_CODE;
    endcase
  end

  assign legal      = (code_n != BAD_CODE);
  assign par_hi_bad = tag_lo[11] ^ (^tag_lo[39:26]);
  assign par_lo_bad = tag_lo[10] ^ (^tag_lo[25:13]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      state_err  <= 1'b0;
      addr_err   <= 1'b0;
      state_code <= '0;
      phys_addr  <= '0;
      bank       <= '0;
      set_num    <= '0;
      lru_order  <= '0;
    end else begin
      out_valid <= chk_valid;
      if (chk_valid) begin
        state_err  <= !legal;
        addr_err   <= legal && (par_hi_bad || par_lo_bad);
        state_code <= code_n;
        phys_addr  <= {tag_lo[LO_W-1:IDX_W], line_index};
        bank       <= {line_index[12], line_index[5]};
        set_num    <= line_index[11:6];
        lru_order  <= tag_hi[21:14];
      end
    end
  end
endmodule

// File: rtl/dcache_tag_checker_sva.sv
module dcache_tag_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        chk_valid,
  input logic [12:0] line_index,
  input logic        out_valid,
  input logic        state_err,
  input logic        addr_err,
  input logic [2:0]  state_code,
  input logic [39:0] phys_addr,
  input logic [1:0]  bank,
  input logic [5:0]  set_num
);
  assert_err_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (state_err == (state_code == 3'd7)));

  assert_illegal_masks_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && state_err |-> !addr_err);

  assert_legal_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !state_err |-> state_code <= 3'd5);

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> $stable(phys_addr) && $stable(state_code) && !out_valid);

  assert_addr_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> phys_addr[12:0] == $past(line_index));

  assert_bank_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> bank == {$past(line_index[12]), $past(line_index[5])}
                  && set_num == $past(line_index[11:6]));
endmodule

bind dcache_tag_checker dcache_tag_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .line_index(line_index),
  .out_valid(out_valid), .state_err(state_err), .addr_err(addr_err),
  .state_code(state_code), .phys_addr(phys_addr), .bank(bank), .set_num(set_num)
);

// File: tb/tb_dcache_tag_checker.sv
`timescale 1ns/1ps
module tb_dcache_tag_checker;
  logic clk = 0, rst_n = 0, chk_valid = 0;
  logic [31:0] tag_hi = '0;
  logic [39:0] tag_lo = '0;
  logic [12:0] line_index = '0;
  logic out_valid, state_err, addr_err;
  logic [2:0] state_code;
  logic [39:0] phys_addr;
  logic [1:0] bank;
  logic [5:0] set_num;
  logic [7:0] lru_order;

  int checks = 0, fails = 0;
  bit done = 0;

  logic e_valid, e_serr, e_aerr;
  logic [2:0] e_code;
  logic [39:0] e_pa;
  logic [1:0] e_bank;
  logic [5:0] e_set;
  logic [7:0] e_lru;

  always #2.5 clk = ~clk;

  dcache_tag_checker dut (.*);

  function automatic int xor_range(logic [39:0] v, int hi, int lo);
    int n = 0;
    for (int i = lo; i <= hi; i++) n += v[i];
    return n % 2;
  endfunction

  function automatic int legal_pos(logic [4:0] s);
    int tbl[6] = '{0, 15, 19, 25, 22, 28};
    for (int i = 0; i < 6; i++) if (tbl[i] == s) return i;
    return 7;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    chk("R9 out_valid", out_valid, e_valid);
    chk("R2/R3 state_err", state_err, e_serr);
    chk("R3/R4/R5 addr_err", addr_err, e_aerr);
    chk("R2/R3 state_code", state_code, e_code);
    chk("R6 phys_addr", phys_addr, e_pa);
    chk("R7 bank", bank, e_bank);
    chk("R7 set_num", set_num, e_set);
    chk("R8 lru_order", lru_order, e_lru);
  endtask

  task automatic model(bit s, logic [31:0] h, logic [39:0] l, logic [12:0] x);
    int p;
    e_valid = s;
    if (!s) return;
    p = legal_pos(h[29:25]);
    e_code = p[2:0];
    e_serr = (p == 7);
    e_aerr = (p != 7) && ((l[11] != xor_range(l, 39, 26)) || (l[10] != xor_range(l, 25, 13)));
    e_pa = {l[39:13], x};
    e_bank = {x[12], x[5]};
    e_set = x[11:6];
    e_lru = h[21:14];
  endtask

  task automatic step(bit s, logic [31:0] h, logic [39:0] l, logic [12:0] x);
    @(negedge clk);
    compare();
    chk_valid = s; tag_hi = h; tag_lo = l; line_index = x;
    model(s, h, l, x);
  endtask

  function automatic logic [39:0] good_lo(logic [39:0] base);
    logic [39:0] r = base;
    r[11] = xor_range(base, 39, 26);
    r[10] = xor_range(base, 25, 13);
    return r;
  endfunction

  function automatic logic [31:0] mk_hi(logic [4:0] st, logic [7:0] lru);
    logic [31:0] r = 32'hA5A5_5A5A;
    r[29:25] = st;
    r[21:14] = lru;
    return r;
  endfunction

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [4:0] legal_states[6] = '{5'h00, 5'h0F, 5'h13, 5'h19, 5'h16, 5'h1C};
    logic [39:0] g;
    {e_valid, e_serr, e_aerr, e_code, e_pa, e_bank, e_set, e_lru} = '0;
    // R1: reset state, with a strobe that must be ignored
    chk_valid = 1; tag_hi = '1; tag_lo = '1; line_index = '1;
    repeat (3) begin @(negedge clk); compare(); end
    chk_valid = 0;
    @(negedge clk); compare();
    rst_n = 1;
    step(0, '0, '0, '0);
    // R2: each legal state, clean parity
    foreach (legal_states[i])
      step(1, mk_hi(legal_states[i], 8'(i * 37)), good_lo(40'h12_3456_7800 + 40'(i) * 40'h1_0000_2000), 13'(i * 417));
    // R3: every illegal state, with bad parity that must be masked
    for (int s = 0; s < 32; s++)
      if (legal_pos(5'(s)) == 7)
        step(1, mk_hi(5'(s), 8'hE4), good_lo(40'hFF_0000_2000) ^ 40'hC00, 13'(s));
    // R4/R5: single-bit flips at range edges for a legal state
    g = good_lo(40'h9A_BCDE_F000);
    foreach (legal_states[i]) begin
      step(1, mk_hi(legal_states[i], 8'h1B), g ^ (40'd1 << 39), 13'h1FFF);
      step(1, mk_hi(legal_states[i], 8'h1B), g ^ (40'd1 << 26), 13'h1020);
      step(1, mk_hi(legal_states[i], 8'h1B), g ^ (40'd1 << 25), 13'h0FDF);
      step(1, mk_hi(legal_states[i], 8'h1B), g ^ (40'd1 << 13), 13'h0000);
      step(1, mk_hi(legal_states[i], 8'h1B), g ^ (40'd1 << 11), 13'h0040);
      step(1, mk_hi(legal_states[i], 8'h1B), g ^ (40'd1 << 10), 13'h1000);
      // bits below 10 are outside both parity ranges
      step(1, mk_hi(legal_states[i], 8'h1B), g ^ 40'h3FF, 13'h0020);
    end
    // R9: hold between strobes
    repeat (4) step(0, $urandom, {$urandom, $urandom}, 13'($urandom));
    // mixed random with R6/R7/R8
    for (int n = 0; n < 400; n++) begin
      logic [39:0] l = {8'($urandom), 32'($urandom)};
      logic [31:0] h = $urandom;
      if (n % 3 == 0) h[29:25] = legal_states[n % 6];
      if (n % 2 == 0) l = good_lo(l);
      step(n % 5 != 4, h, l, 13'($urandom));
    end
    step(0, '0, '0, '0);
    step(0, '0, '0, '0);
    @(negedge clk); compare();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule